// File: doc/BRIEF.md
# Packed-Syllable Instruction Sequencer

This block sits in front of the execution unit of a small stack machine. It reads 32-bit instruction words through a synchronous memory port. The memory returns the requested word one cycle after the request. The block sorts each word by its top two bits:

- An immediate word becomes one push operation carrying the expanded constant.
- A syllable word is cut into five 6-bit operations, which are offered one after another.
- A reserved word stops the block and raises an illegal-instruction flag.

Each operation goes to the execution unit over a valid/ready handshake. The block also reports the program counter and the syllable counter for the item on offer. The execution unit can redirect the block at any time, after a jump or a taken branch. A redirect drops whatever remains of the current word and restarts fetch at the target word. When a halt syllable is accepted, the block stops and holds its counters until reset.

Top module: `pksyl_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block requests the word at the reset address. In that state pc equals the reset address (0 by default), sc is 0, op_valid is low, and illegal and halted are low.
- R2: A word with bit 31 set produces exactly one operation with op_is_imm=1 and op_data = {word[30:0], 1'b0}. Fetch then moves on to the next word.
- R3: A word with bits 31..30 = 00 produces five operations with op_is_imm=0. They come from bits 29..24, 23..18, 17..12, 11..6 and 5..0, in that order. Each syllable is zero-extended into op_data[5:0].
- R4: Let A be the address of the word currently on offer. While an operation from that word is offered, pc = A+4. For the k-th syllable (k = 1..5), sc = k mod 5. For an immediate, sc = 0. While the block is fetching word A, pc = A and sc = 0.
- R5: An offered operation holds op_data, op_is_imm, pc and sc unchanged for as long as op_ready is low. The block advances only on a cycle with op_valid and op_ready both high.
- R6: The cycle after the last item of word A is accepted, the block requests word A+4. The first operation of that word is offered two cycles after the request. Syllables of the same word are offered on back-to-back cycles.
- R7: A cycle with redir_valid high, unless the block is halted or illegal, discards the rest of the current word. On the next cycle the block requests redir_addr with op_valid low, pc = redir_addr and sc = 0. The next operation comes from the target word.
- R8: A word with bits 31..30 = 01 sets illegal. The flag stays set until reset. No further fetches or operations occur, pc holds the address of that word, sc is 0, and redirects are ignored.
- R9: When a syllable with code 000000 is accepted, the block sets halted. Until reset, pc and sc keep the values they had while that syllable was offered. No fetches or operations occur, and redirects are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Instruction read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rdata | input | WORD_W | Word returned one cycle after the request |
| op_valid | output | 1 | An operation is on offer |
| op_ready | input | 1 | The execution unit takes the offered operation |
| op_is_imm | output | 1 | 1: push of an immediate, 0: syllable |
| op_data | output | WORD_W | Expanded immediate, or the zero-extended syllable |
| redir_valid | input | 1 | Jump or taken-branch redirect |
| redir_addr | input | AW | Redirect target word address |
| pc | output | AW | Program counter (next word to execute) |
| sc | output | IDX_W | Syllable counter (next syllable, 0..4) |
| illegal | output | 1 | Reserved-format word seen (sticky) |
| halted | output | 1 | Halt syllable accepted (sticky) |

## Verification
Each result has a fixed latency:

- A word request leads to its first operation two cycles later: one cycle for the memory return and one for decode.
- Syllables of a word follow each other on consecutive cycles.
- A redirect shows up as a new request one cycle after the redirect cycle.
- The illegal and halted flags appear one cycle after the decode or the acceptance that caused them.

The bench counts the falling edges between one accepted item and the next. It compares that count with the expected gap in each vector and samples every output on a falling edge. Directed cases read the request address and counters in the exact cycle after a redirect, a stall, a halt and a reserved word.

// File: rtl/pksyl_pkg.sv
package pksyl_pkg;
   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_ISSUE,
      ST_HALT,
      ST_ILLEGAL
   } seq_state_e;

   typedef enum logic [1:0] {
      FMT_IMM,
      FMT_RSVD,
      FMT_SYL
   } word_fmt_e;
endpackage

// File: rtl/pksyl_decode.sv
module pksyl_decode
   import pksyl_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   output word_fmt_e         fmt,
   output logic [WORD_W-1:0] imm_val
);
   always_comb begin
      if (word[WORD_W-1])      fmt = FMT_IMM;
      else if (word[WORD_W-2]) fmt = FMT_RSVD;
      else                     fmt = FMT_SYL;
   end

   // immediate payload moves up one place, bit 0 filled with zero
   assign imm_val = {word[WORD_W-2:0], 1'b0};
endmodule

// File: rtl/pksyl_pick.sv
module pksyl_pick #(
   parameter int SYL_W = 6,
   parameter int NSYL  = 5,
   parameter int IDX_W = 3
) (
   input  logic [NSYL*SYL_W-1:0] payload,
   input  logic [IDX_W-1:0]      idx,
   output logic [SYL_W-1:0]      syl
);
   logic [SYL_W-1:0] slots [NSYL];

   // slot 0 is the most significant field: first to execute
   for (genvar i = 0; i < NSYL; i++) begin : g_slot
      assign slots[i] = payload[(NSYL-i)*SYL_W-1 -: SYL_W];
   end

   always_comb begin
      syl = '0;
      for (int j = 0; j < NSYL; j++) begin
         if (idx == IDX_W'(j)) syl = slots[j];
      end
   end
endmodule

// File: rtl/pksyl_sequencer.sv
module pksyl_sequencer
   import pksyl_pkg::*;
#(
   parameter int               AW        = 32,
   parameter int               WORD_W    = 32,
   parameter int               SYL_W     = 6,
   parameter int               NSYL      = 5,
   parameter logic [AW-1:0]    RESET_PC  = '0,
   parameter logic [SYL_W-1:0] HALT_CODE = '0,
   localparam int              IDX_W     = (NSYL > 1) ? $clog2(NSYL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              op_valid,
   input  logic              op_ready,
   output logic              op_is_imm,
   output logic [WORD_W-1:0] op_data,
   input  logic              redir_valid,
   input  logic [AW-1:0]     redir_addr,
   output logic [AW-1:0]     pc,
   output logic [IDX_W-1:0]  sc,
   output logic              illegal,
   output logic              halted
);
   localparam int              PAY_W = NSYL * SYL_W;
   localparam int              STEP  = WORD_W / 8;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYL - 1);

   if (WORD_W != PAY_W + 2) begin : g_bad_pack
      $error("WORD_W must equal NSYL*SYL_W + 2");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (AW < 3) begin : g_bad_aw
      $error("AW too small");
   end

   seq_state_e        state;
   logic [AW-1:0]     cur_addr;
   logic [WORD_W-1:0] word_q;
   logic              imm_q;
   logic [IDX_W-1:0]  idx;

   word_fmt_e         fmt;
   logic [WORD_W-1:0] imm_val;
   logic [SYL_W-1:0]  cur_syl;
   logic [IDX_W-1:0]  sc_next;
   logic              show_next;

   pksyl_decode #(.WORD_W(WORD_W)) u_decode (
      .word    (mem_rdata),
      .fmt     (fmt),
      .imm_val (imm_val)
   );

   pksyl_pick #(.SYL_W(SYL_W), .NSYL(NSYL), .IDX_W(IDX_W)) u_pick (
      .payload (word_q[PAY_W-1:0]),
      .idx     (idx),
      .syl     (cur_syl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_FETCH;
         cur_addr <= RESET_PC;
         word_q   <= '0;
         imm_q    <= 1'b0;
         idx      <= '0;
      end else begin
         case (state)
            ST_FETCH: begin
               if (redir_valid) cur_addr <= redir_addr;
               else             state    <= ST_DECODE;
            end
            ST_DECODE: begin
               idx <= '0;
               if (redir_valid) begin
                  cur_addr <= redir_addr;
                  state    <= ST_FETCH;
               end else begin
                  case (fmt)
                     FMT_IMM: begin
                        word_q <= imm_val;
                        imm_q  <= 1'b1;
                        state  <= ST_ISSUE;
                     end
                     FMT_SYL: begin
                        word_q <= mem_rdata;
                        imm_q  <= 1'b0;
                        state  <= ST_ISSUE;
                     end
                     default: state <= ST_ILLEGAL;
                  endcase
               end
            end
            ST_ISSUE: begin
               if (redir_valid) begin
                  cur_addr <= redir_addr;
                  idx      <= '0;
                  state    <= ST_FETCH;
               end else if (op_ready) begin
                  if (!imm_q && cur_syl == HALT_CODE) begin
                     state <= ST_HALT;
                  end else if (imm_q || idx == LAST) begin
                     cur_addr <= cur_addr + AW'(STEP);
                     idx      <= '0;
                     state    <= ST_FETCH;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_HALT, ST_ILLEGAL: state <= state;
            default: state <= ST_FETCH;
         endcase
      end
   end

   assign sc_next   = (idx == LAST) ? '0 : idx + 1'b1;
   assign show_next = (state == ST_ISSUE) || (state == ST_HALT);

   assign mem_req   = (state == ST_FETCH);
   assign mem_addr  = cur_addr;
   assign op_valid  = (state == ST_ISSUE);
   assign op_is_imm = imm_q;
   assign op_data   = imm_q ? word_q : WORD_W'(cur_syl);
   assign pc        = show_next ? cur_addr + AW'(STEP) : cur_addr;
   assign sc        = (show_next && !imm_q) ? sc_next : '0;
   assign illegal   = (state == ST_ILLEGAL);
   assign halted    = (state == ST_HALT);
endmodule

// File: rtl/pksyl_sequencer_chk.sv
module pksyl_sequencer_chk #(
   parameter int AW     = 32,
   parameter int WORD_W = 32,
   parameter int NSYL   = 5,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [AW-1:0]     mem_addr,
   input logic              op_valid,
   input logic              op_ready,
   input logic              op_is_imm,
   input logic [WORD_W-1:0] op_data,
   input logic              redir_valid,
   input logic [AW-1:0]     redir_addr,
   input logic [AW-1:0]     pc,
   input logic [IDX_W-1:0]  sc,
   input logic              illegal,
   input logic              halted
);
   a_r4_sc_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sc) < NSYL);

   a_r2_imm_shape: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_is_imm |-> sc == '0 && !op_data[0]);

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready && !redir_valid |=>
         op_valid && $stable(op_data) && $stable(op_is_imm) && $stable(pc) && $stable(sc));

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && op_valid));

   a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid && !halted && !illegal |=>
         mem_req && !op_valid && mem_addr == $past(redir_addr) && sc == '0);

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> illegal && $stable(pc));

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req && !op_valid);

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(pc) && $stable(sc));

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req && !op_valid && !illegal);
endmodule

bind pksyl_sequencer pksyl_sequencer_chk #(
   .AW(AW), .WORD_W(WORD_W), .NSYL(NSYL), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
   .op_valid(op_valid), .op_ready(op_ready), .op_is_imm(op_is_imm),
   .op_data(op_data), .redir_valid(redir_valid), .redir_addr(redir_addr),
   .pc(pc), .sc(sc), .illegal(illegal), .halted(halted)
);

// File: tb/pksyl_sequencer_bench.sv
module pksyl_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        op_valid;
   logic        op_ready = 1'b1;
   logic        op_is_imm;
   logic [31:0] op_data;
   logic        redir_valid = 1'b0;
   logic [31:0] redir_addr = '0;
   logic [31:0] pc;
   logic [2:0]  sc;
   logic        illegal;
   logic        halted;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pksyl_sequencer u_pksyl_sequencer (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .op_valid(op_valid), .op_ready(op_ready),
      .op_is_imm(op_is_imm), .op_data(op_data), .redir_valid(redir_valid),
      .redir_addr(redir_addr), .pc(pc), .sc(sc), .illegal(illegal),
      .halted(halted)
   );

   function automatic logic [31:0] pack5(input logic [5:0] a, b, c, d, e);
      return {2'b00, a, b, c, d, e};
   endfunction

   logic [31:0] mem [0:31];
   always_ff @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[6:2]];

   // {gap[1:0], is_imm, data[31:0], pc[31:0], sc[3:0]}
   localparam logic [70:0] VEC [12] = '{
      {2'd1, 1'b1, 32'h8080_8080, 32'h04, 4'd0},
      {2'd2, 1'b0, 32'h21, 32'h08, 4'd1},
      {2'd0, 1'b0, 32'h01, 32'h08, 4'd2},
      {2'd0, 1'b0, 32'h22, 32'h08, 4'd3},
      {2'd0, 1'b0, 32'h0C, 32'h08, 4'd4},
      {2'd0, 1'b0, 32'h01, 32'h08, 4'd0},
      {2'd2, 1'b1, 32'h0000_0002, 32'h0C, 4'd0},
      {2'd2, 1'b0, 32'h3F, 32'h10, 4'd1},
      {2'd0, 1'b0, 32'h01, 32'h10, 4'd2},
      {2'd0, 1'b0, 32'h01, 32'h10, 4'd3},
      {2'd0, 1'b0, 32'h01, 32'h10, 4'd4},
      {2'd0, 1'b0, 32'h0E, 32'h10, 4'd0}
   };

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // waits for the next offered op; gap = falling edges with no op on offer
   task automatic wait_op(output int gap);
      gap = 0;
      @(negedge clk);
      while (!op_valid && gap < 40) begin
         gap++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      op_ready = 1'b1;
      redir_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 reset state", {mem_req, mem_addr, op_valid, illegal, halted, pc, 1'b0, sc},
          {1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd0});
      rst_n = 1'b1;
   endtask

   // redirect issued while in the fetch state right after reset
   task automatic jump_to(input logic [31:0] a);
      redir_valid = 1'b1;
      redir_addr  = a;
      @(negedge clk);
      redir_valid = 1'b0;
      chk("R7 redirect from fetch", {mem_req, mem_addr, op_valid}, {1'b1, a, 1'b0});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int g;
      for (int k = 0; k < 32; k++) mem[k] = pack5(6'h01, 6'h01, 6'h01, 6'h01, 6'h01);
      mem[0]  = 32'hC040_4040;
      mem[1]  = pack5(6'h21, 6'h01, 6'h22, 6'h0C, 6'h01);
      mem[2]  = 32'h8000_0001;
      mem[3]  = pack5(6'h3F, 6'h01, 6'h01, 6'h01, 6'h0E);
      mem[4]  = 32'h4000_0000;
      mem[8]  = pack5(6'h01, 6'h0E, 6'h21, 6'h21, 6'h21);
      mem[12] = 32'h8000_0005;
      mem[16] = pack5(6'h01, 6'h00, 6'h21, 6'h21, 6'h21);

      // vector walk: R2 R3 R4 R6, ending on a reserved word
      do_reset();
      for (int i = 0; i < 12; i++) begin
         wait_op(g);
         chk($sformatf("R2/R3/R4 vec %0d op", i),
             {op_valid, op_is_imm, op_data, pc, 1'b0, sc},
             {1'b1, VEC[i][68], VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]});
         chk($sformatf("R6 vec %0d gap", i), 128'(g), 128'(VEC[i][70:69]));
         @(posedge clk);
      end
      repeat (3) @(negedge clk);
      chk("R8 illegal stop", {illegal, mem_req, op_valid, pc, 1'b0, sc},
          {1'b1, 1'b0, 1'b0, 32'h10, 4'd0});
      redir_valid = 1'b1;
      redir_addr  = 32'h0;
      repeat (3) @(negedge clk);
      redir_valid = 1'b0;
      chk("R8 redirect ignored", {illegal, mem_req, op_valid, pc}, {1'b1, 1'b0, 1'b0, 32'h10});

      // stall: R5
      do_reset();
      op_ready = 1'b0;
      wait_op(g);
      repeat (3) @(negedge clk);
      chk("R5 stall hold", {op_valid, op_is_imm, op_data, pc, 1'b0, sc},
          {1'b1, 1'b1, 32'h8080_8080, 32'h04, 4'd0});
      op_ready = 1'b1;
      @(posedge clk);
      wait_op(g);
      chk("R5 single accept", {op_is_imm, op_data, pc, 1'b0, sc, 8'(g)},
          {1'b0, 32'h21, 32'h08, 4'd1, 8'd2});

      // redirect mid-word: R7
      do_reset();
      jump_to(32'h20);
      wait_op(g);
      chk("R7 target first op", {op_data, pc, 1'b0, sc}, {32'h01, 32'h24, 4'd1});
      @(posedge clk);
      wait_op(g);
      chk("R7 jump syllable", {op_data, pc, 1'b0, sc}, {32'h0E, 32'h24, 4'd2});
      redir_valid = 1'b1;
      redir_addr  = 32'h30;
      @(negedge clk);
      redir_valid = 1'b0;
      chk("R7 fetch after redirect", {mem_req, mem_addr, op_valid, pc, 1'b0, sc},
          {1'b1, 32'h30, 1'b0, 32'h30, 4'd0});
      wait_op(g);
      chk("R7 rest discarded", {op_is_imm, op_data, pc, 1'b0, sc, 8'(g)},
          {1'b1, 32'h0A, 32'h34, 4'd0, 8'd1});

      // halt syllable: R9
      do_reset();
      jump_to(32'h40);
      wait_op(g);
      @(posedge clk);
      wait_op(g);
      chk("R9 halt offered", {op_data, pc, 1'b0, sc}, {32'h00, 32'h44, 4'd2});
      @(negedge clk);
      chk("R9 halted", {halted, op_valid, mem_req, pc, 1'b0, sc},
          {1'b1, 1'b0, 1'b0, 32'h44, 4'd2});
      redir_valid = 1'b1;
      redir_addr  = 32'h0;
      repeat (2) @(negedge clk);
      redir_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 frozen", {halted, op_valid, mem_req, pc, 1'b0, sc},
          {1'b1, 1'b0, 1'b0, 32'h44, 4'd2});

      do_reset();
      @(negedge clk);
      chk("R1 cleared by reset", {halted, illegal}, 2'b00);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule